// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial-side controller of an 8192 x 8 byte-addressed nonvolatile memory. It oversamples chip select, serial clock and serial data in with the system clock and finds the serial clock edges. It then decodes a single command byte for each chip-select window. Memory commands carry a two-byte address, after which data bytes stream to or from a synchronous RAM port. The address steps after every byte and wraps from the top of the array back to zero. Writes reach the array as each byte completes, so there is no page buffer and no busy state.

Status and write protection live in a separate unit. This block reports write-enable, write-disable and status-write commands to that unit as single-cycle pulses. It signals the end of any window that held a write command, and it drives out the status byte the unit supplies. For every write byte the unit says whether the target address may be written. The serial output has a separate enable and is released whenever no read or status data is being sent.

Top module: `spi_nvm_front`

## Requirements
- R1: Command byte 06h gives one `ev_wren` pulse and command byte 04h gives one `ev_wrdi` pulse. Neither command takes any further bytes.
- R2: After command 05h, the next byte on `sdo` is `stat_rdata`, MSB first. Only one status byte is sent, and `sdo_oe` is low for any later byte in that window.
- R3: After command 01h, the next received byte appears on `ev_sr_data` with one `ev_wrsr` pulse. Later bytes in that window are ignored.
- R4: At chip-select deassertion, a window whose command was 01h or 02h gives exactly one `ev_wr_end` pulse. Other windows give none.
- R5: Command 03h is followed by a 16-bit address, high byte first. Bits 15..13 are ignored. Read data is driven on `sdo` MSB first and changes only after falling SCK edges. Both SCK idle levels (modes 0 and 3) work.
- R6: Consecutive read bytes come from consecutive addresses, and 1FFFh is followed by 0000h.
- R7: Command 02h is followed by a 16-bit address (bits 15..13 ignored). Each data byte is written on the memory port after its eighth bit. The address then advances by one and wraps from 1FFFh to 0000h.
- R8: A write byte whose address has `wr_allow` low is not written, but the address still advances.
- R9: `sdo_oe` is high only while read or status data is being driven. `sdi` is ignored during read data bytes.
- R10: Only the first byte of a window is taken as a command. Later bytes are never decoded as commands.
- R11: An unknown command byte makes the rest of the window have no effect: no events, no writes, and `sdo_oe` stays low.
- R12: A byte cut short by chip-select deassertion is discarded and not written.
- R13: Low `rst_n` drops `sdo_oe` and aborts the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| mem_addr | output | 13 | RAM byte address |
| mem_rd | output | 1 | RAM read strobe; data is valid one clock later |
| mem_rdata | input | 8 | RAM read data |
| mem_wr | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| wr_allow | input | 1 | Status unit: mem_addr may be written |
| stat_rdata | input | 8 | Status byte to send for command 05h |
| ev_wren | output | 1 | Write-enable command pulse |
| ev_wrdi | output | 1 | Write-disable command pulse |
| ev_wrsr | output | 1 | Status-write byte pulse |
| ev_sr_data | output | 8 | Byte received for a status write |
| ev_wr_end | output | 1 | Pulse at the end of a write or status-write window |

## Verification
The bench sweeps read starts near the array top, including 1FFDh, 1FFFh and addresses with the ignored high bits set. A design that carried those bits into the address, or failed to wrap, returns wrong patterns. It writes across a single blocked address to confirm the address still advances there. A design that stalled at the blocked address would shift every later byte down by one location. It ends windows in the middle of a byte and sends extra command bytes, unknown commands and reset during a read. These expose a design that commits partial bytes, decodes a second command, or drives sdo when it must not. Both SCK idle levels are used, so a design that took the first falling edge in mode 3 as a data edge would shift its output by one bit.

// File: rtl/spinvm_pkg.sv
package spinvm_pkg;
   localparam logic [7:0] CMD_WREN = 8'h06;
   localparam logic [7:0] CMD_WRDI = 8'h04;
   localparam logic [7:0] CMD_RDSR = 8'h05;
   localparam logic [7:0] CMD_WRSR = 8'h01;
   localparam logic [7:0] CMD_READ = 8'h03;
   localparam logic [7:0] CMD_WRIT = 8'h02;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT,
      ST_SRW,
      ST_SRR,
      ST_SKIP
   } fe_state_e;
endpackage

// File: rtl/spinvm_sync.sv
module spinvm_sync #(
   parameter int          W      = 3,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST_V = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spinvm_serdes.sv
module spinvm_serdes #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         win_on,
   input  logic         rise,
   input  logic         fall,
   input  logic         sdi,
   input  logic         tx_en,
   input  logic [W-1:0] tx_byte,
   output logic         rx_done,
   output logic [W-1:0] rx_byte,
   output logic         tx_start,
   output logic         sdo,
   output logic         sdo_oe
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] rcnt, tcnt;
   logic [W-1:0]  rx_sr, tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt     <= '0;
         tcnt     <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rx_done  <= 1'b0;
         rx_byte  <= '0;
         tx_start <= 1'b0;
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
      end else begin
         rx_done  <= 1'b0;
         tx_start <= 1'b0;
         if (!win_on) begin
            rcnt <= '0;
         end else if (rise) begin
            rx_sr <= {rx_sr[W-2:0], sdi};
            rcnt  <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
            if (rcnt == LAST) begin
               rx_done <= 1'b1;
               rx_byte <= {rx_sr[W-2:0], sdi};
            end
         end
         if (!win_on || !tx_en) begin
            tcnt   <= '0;
            sdo_oe <= 1'b0;
         end else if (fall) begin
            sdo_oe <= 1'b1;
            tcnt   <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
            if (tcnt == '0) begin
               sdo      <= tx_byte[W-1];
               tx_sr    <= tx_byte << 1;
               tx_start <= 1'b1;
            end else begin
               sdo   <= tx_sr[W-1];
               tx_sr <= tx_sr << 1;
            end
         end
      end
   end

   // R5
   tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(fall));
endmodule

// File: rtl/spinvm_cmd.sv
module spinvm_cmd
   import spinvm_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_on,
   input  logic              rx_done,
   input  logic [W-1:0]      rx_byte,
   input  logic              tx_start,
   input  logic              wr_allow,
   input  logic [W-1:0]      mem_rdata,
   input  logic [W-1:0]      stat_rdata,
   output logic              tx_en,
   output logic [W-1:0]      tx_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [W-1:0]      mem_wdata,
   output logic              ev_wren,
   output logic              ev_wrdi,
   output logic              ev_wrsr,
   output logic [W-1:0]      ev_sr_data,
   output logic              ev_wr_end
);
   fe_state_e  st;
   logic [W-1:0] addr_hi, rd_buf;
   logic       rd_op, op_wr, adv_pend, fetch_pend, rd_vld;

   assign tx_en   = (st == ST_RDAT) || (st == ST_SRR);
   assign tx_byte = (st == ST_SRR) ? stat_rdata : rd_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_CMD;
         addr_hi    <= '0;
         rd_buf     <= '0;
         rd_op      <= 1'b0;
         op_wr      <= 1'b0;
         adv_pend   <= 1'b0;
         fetch_pend <= 1'b0;
         rd_vld     <= 1'b0;
         mem_addr   <= '0;
         mem_rd     <= 1'b0;
         mem_wr     <= 1'b0;
         mem_wdata  <= '0;
         ev_wren    <= 1'b0;
         ev_wrdi    <= 1'b0;
         ev_wrsr    <= 1'b0;
         ev_sr_data <= '0;
         ev_wr_end  <= 1'b0;
      end else begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         ev_wren   <= 1'b0;
         ev_wrdi   <= 1'b0;
         ev_wrsr   <= 1'b0;
         ev_wr_end <= 1'b0;
         rd_vld    <= mem_rd;
         if (rd_vld) rd_buf <= mem_rdata;
         if (adv_pend) begin
            mem_addr <= mem_addr + 1'b1;
            adv_pend <= 1'b0;
         end
         if (fetch_pend) begin
            mem_rd     <= 1'b1;
            fetch_pend <= 1'b0;
         end
         if (!win_on) begin
            st         <= ST_CMD;
            ev_wr_end  <= op_wr;
            op_wr      <= 1'b0;
            fetch_pend <= 1'b0;
         end else if (rx_done) begin
            case (st)
               ST_CMD: begin
                  case (rx_byte)
                     CMD_WREN: begin ev_wren <= 1'b1; st <= ST_SKIP; end
                     CMD_WRDI: begin ev_wrdi <= 1'b1; st <= ST_SKIP; end
                     CMD_RDSR: st <= ST_SRR;
                     CMD_WRSR: begin op_wr <= 1'b1; st <= ST_SRW; end
                     CMD_READ: begin rd_op <= 1'b1; st <= ST_AHI; end
                     CMD_WRIT: begin rd_op <= 1'b0; op_wr <= 1'b1; st <= ST_AHI; end
                     default:  st <= ST_SKIP;
                  endcase
               end
               ST_AHI: begin
                  addr_hi <= rx_byte;
                  st      <= ST_ALO;
               end
               ST_ALO: begin
                  mem_addr <= ADDR_W'({addr_hi, rx_byte});
                  if (rd_op) begin
                     fetch_pend <= 1'b1;
                     st         <= ST_RDAT;
                  end else begin
                     st <= ST_WDAT;
                  end
               end
               ST_WDAT: begin
                  if (wr_allow) begin
                     mem_wr    <= 1'b1;
                     mem_wdata <= rx_byte;
                  end
                  adv_pend <= 1'b1;
               end
               ST_SRW: begin
                  ev_wrsr    <= 1'b1;
                  ev_sr_data <= rx_byte;
                  st         <= ST_SKIP;
               end
               ST_SRR:  st <= ST_SKIP;
               default: ;
            endcase
         end else if (tx_start && st == ST_RDAT) begin
            mem_addr   <= mem_addr + 1'b1;
            fetch_pend <= 1'b1;
         end
      end
   end

   // R8
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(wr_allow));

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> (mem_addr == $past(mem_addr) + 1'b1));

   // R10
   ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_wren, ev_wrdi, ev_wrsr, mem_wr}));
endmodule

// File: rtl/spi_nvm_front.sv
module spi_nvm_front #(
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic              wr_allow,
   input  logic [7:0]        stat_rdata,
   output logic              ev_wren,
   output logic              ev_wrdi,
   output logic              ev_wrsr,
   output logic [7:0]        ev_sr_data,
   output logic              ev_wr_end
);
   localparam int BW = 8;

   generate
      if (ADDR_W < 1 || ADDR_W > 2 * BW) begin : g_bad_addr
         $error("ADDR_W must fit in the two address bytes");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       cs_s, sck_s, sdi_s, sck_p, win_on, rise, fall;
   logic       rx_done, tx_start, tx_en;
   logic [BW-1:0] rx_byte, tx_byte;

   spinvm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(pins_s));

   assign cs_s  = pins_s[2];
   assign sck_s = pins_s[1];
   assign sdi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_p <= 1'b0;
      else        sck_p <= sck_s;
   end

   assign win_on = !cs_s;
   assign rise   = win_on && sck_s && !sck_p;
   assign fall   = win_on && !sck_s && sck_p;

   spinvm_serdes #(.W(BW)) u_serdes (
      .clk(clk), .rst_n(rst_n), .win_on(win_on), .rise(rise), .fall(fall),
      .sdi(sdi_s), .tx_en(tx_en), .tx_byte(tx_byte), .rx_done(rx_done),
      .rx_byte(rx_byte), .tx_start(tx_start), .sdo(sdo), .sdo_oe(sdo_oe));

   spinvm_cmd #(.ADDR_W(ADDR_W), .W(BW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .win_on(win_on), .rx_done(rx_done),
      .rx_byte(rx_byte), .tx_start(tx_start), .wr_allow(wr_allow),
      .mem_rdata(mem_rdata), .stat_rdata(stat_rdata), .tx_en(tx_en),
      .tx_byte(tx_byte), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ev_wren(ev_wren),
      .ev_wrdi(ev_wrdi), .ev_wrsr(ev_wrsr), .ev_sr_data(ev_sr_data),
      .ev_wr_end(ev_wr_end));

   // R9
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> $past(win_on));
endmodule

// File: tb/sim_spi_nvm_front.sv
module sim_spi_nvm_front;
   localparam int HP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe, mem_rd, mem_wr;
   logic [12:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00, mem_wdata, stat_rdata = 8'h00, ev_sr_data;
   logic ev_wren, ev_wrdi, ev_wrsr, ev_wr_end;
   logic prot_en = 1'b0;
   logic [12:0] prot_addr = 13'h0;
   logic wr_allow;

   int nvec = 0, nfail = 0;
   int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_end = 0, n_w = 0, n_oe = 0;
   logic [12:0] wl_a [128];
   logic [7:0]  wl_d [128];
   bit done = 0;

   always #4 clk = ~clk;

   assign wr_allow = !prot_en || (mem_addr != prot_addr);

   spi_nvm_front u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .wr_allow(wr_allow), .stat_rdata(stat_rdata), .ev_wren(ev_wren),
      .ev_wrdi(ev_wrdi), .ev_wrsr(ev_wrsr), .ev_sr_data(ev_sr_data),
      .ev_wr_end(ev_wr_end));

   function automatic logic [7:0] pat(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], a[2:0]};
   endfunction

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= pat(mem_addr);
      if (mem_wr) begin
         wl_a[n_w % 128] <= mem_addr;
         wl_d[n_w % 128] <= mem_wdata;
         n_w <= n_w + 1;
      end
      if (ev_wren)   n_wren <= n_wren + 1;
      if (ev_wrdi)   n_wrdi <= n_wrdi + 1;
      if (ev_wrsr)   n_wrsr <= n_wrsr + 1;
      if (ev_wr_end) n_end  <= n_end + 1;
      if (sdo_oe)    n_oe   <= n_oe + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_open(input logic m3);
      sck <= m3;
      waitc(HP);
      cs_n <= 1'b0;
      waitc(HP);
   endtask

   task automatic cs_close(input logic m3);
      if (!m3) sck <= 1'b0;
      waitc(HP);
      cs_n <= 1'b1;
      waitc(2 * HP);
   endtask

   task automatic xbits(input logic [7:0] t, input int n, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i > 7 - n; i--) begin
         sck <= 1'b0;
         sdi <= t[i];
         waitc(HP);
         r[i] = sdo;
         sck <= 1'b1;
         waitc(HP);
      end
   endtask

   task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
      xbits(t, 8, r);
   endtask

   task automatic rd_run(input logic [15:0] a, input int n, input logic m3);
      logic [7:0] r;
      int w0 = n_w;
      cs_open(m3);
      xbyte(8'h03, r);
      xbyte(a[15:8], r);
      xbyte(a[7:0], r);
      for (int k = 0; k < n; k++) begin
         xbyte(8'hA5 ^ 8'(k), r);
         check((k == 0) ? "R5 read first byte" : "R6 read next byte",
               {24'h0, r}, {24'h0, pat(13'(a[12:0] + 13'(k)))});
      end
      cs_close(m3);
      check("R9 sdi ignored during read", n_w, w0);
   endtask

   task automatic wr_run(input logic [15:0] a, input int n, input logic m3, input logic [7:0] seed);
      logic [7:0] r;
      cs_open(m3);
      xbyte(8'h02, r);
      xbyte(a[15:8], r);
      xbyte(a[7:0], r);
      for (int k = 0; k < n; k++) xbyte(seed + 8'(k * 37), r);
      cs_close(m3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int w0, e0, o0, wr0;
      waitc(5);
      check("R13 reset oe", {31'h0, sdo_oe}, 0);
      rst_n <= 1'b1;
      waitc(5);
      check("R13 no write after reset", n_w, 0);

      // R1 write-enable, mode 0
      cs_open(0); xbyte(8'h06, r); cs_close(0);
      check("R1 wren pulse", n_wren, 1);
      // R1 write-disable, mode 3
      cs_open(1); xbyte(8'h04, r); cs_close(1);
      check("R1 wrdi pulse", n_wrdi, 1);
      check("R4 no end event for wren/wrdi", n_end, 0);

      // R2 status read, both modes
      for (int m = 0; m < 2; m++) begin
         stat_rdata <= (m == 0) ? 8'hA5 : 8'h3C;
         cs_open(m[0]);
         xbyte(8'h05, r);
         xbyte(8'h00, r);
         check("R2 status byte", {24'h0, r}, (m == 0) ? 32'hA5 : 32'h3C);
         waitc(2);
         o0 = n_oe;
         xbyte(8'h00, r);
         check("R2 single status byte, oe low after", n_oe, o0);
         cs_close(m[0]);
      end

      // R3 / R4 status write
      cs_open(0); xbyte(8'h01, r); xbyte(8'h8C, r); xbyte(8'h11, r); cs_close(0);
      check("R3 wrsr pulse count", n_wrsr, 1);
      check("R3 wrsr data", {24'h0, ev_sr_data}, 32'h8C);
      check("R4 end event after wrsr", n_end, 1);

      // R7 write with wrap, ignored high bits
      w0 = n_w;
      o0 = n_oe;
      wr_run(16'hFFFE, 3, 0, 8'h11);
      check("R7 write count", n_w - w0, 3);
      for (int k = 0; k < 3; k++) begin
         check("R7 write addr wrap", {19'h0, wl_a[w0 + k]}, {19'h0, 13'(13'h1FFE + 13'(k))});
         check("R7 write data", {24'h0, wl_d[w0 + k]}, {24'h0, 8'h11 + 8'(k * 37)});
      end
      check("R4 end event after write", n_end, 2);
      check("R9 oe stays low in write", n_oe, o0);

      // R5 / R6 read sweep
      rd_run(16'h0000, 3, 0);
      rd_run(16'hE123, 2, 1);
      rd_run(16'h1FFD, 5, 0);
      rd_run(16'hFFFF, 3, 1);
      rd_run(16'h4AB7, 2, 0);
      rd_run(16'h0800, 1, 1);

      // R7 write sweep both modes
      for (int s = 0; s < 4; s++) begin
         logic [15:0] a = 16'(s * 16'h0777 + 16'h0101);
         w0 = n_w;
         wr_run(a, 3, s[0], 8'(s * 9));
         check("R7 sweep count", n_w - w0, 3);
         for (int k = 0; k < 3; k++) begin
            check("R7 sweep addr", {19'h0, wl_a[w0 + k]}, {19'h0, 13'(a[12:0] + 13'(k))});
            check("R7 sweep data", {24'h0, wl_d[w0 + k]}, {24'h0, 8'(s * 9) + 8'(k * 37)});
         end
      end

      // R8 blocked address in the middle of a burst
      prot_en <= 1'b1;
      prot_addr <= 13'h0040;
      w0 = n_w;
      wr_run(16'h003F, 3, 0, 8'hA1);
      check("R8 only allowed bytes written", n_w - w0, 2);
      check("R8 first addr", {19'h0, wl_a[w0]}, 32'h3F);
      check("R8 addr advanced past block", {19'h0, wl_a[w0 + 1]}, 32'h41);
      check("R8 data after block", {24'h0, wl_d[w0 + 1]}, {24'h0, 8'hA1 + 8'd74});
      prot_en <= 1'b0;

      // R11 unknown command
      w0 = n_w; e0 = n_wren; o0 = n_oe; wr0 = n_wrsr;
      cs_open(1);
      xbyte(8'hAB, r); xbyte(8'h06, r); xbyte(8'h05, r); xbyte(8'h02, r);
      cs_close(1);
      check("R11 no wren", n_wren, e0);
      check("R11 no oe", n_oe, o0);
      check("R11 no write", n_w, w0);
      check("R11 no wrsr", n_wrsr, wr0);

      // R10 second command byte ignored
      e0 = n_wren; wr0 = n_end;
      cs_open(0); xbyte(8'h06, r); xbyte(8'h06, r); xbyte(8'h02, r); cs_close(0);
      check("R10 single wren", n_wren - e0, 1);
      check("R10 no write-end from later byte", n_end, wr0);

      // R12 partial byte
      w0 = n_w;
      cs_open(0);
      xbyte(8'h02, r); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'h55, r);
      xbits(8'hFF, 5, r);
      cs_close(0);
      check("R12 partial byte dropped", n_w - w0, 1);
      check("R12 full byte kept", {24'h0, wl_d[w0]}, 32'h55);

      // R13 reset mid-read
      cs_open(0);
      xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r);
      xbits(8'h00, 3, r);
      check("R13 oe before reset", {31'h0, sdo_oe}, 1);
      rst_n <= 1'b0;
      waitc(3);
      check("R13 oe dropped in reset", {31'h0, sdo_oe}, 0);
      cs_n <= 1'b1;
      sck <= 1'b0;
      waitc(HP);
      rst_n <= 1'b1;
      waitc(HP);
      rd_run(16'h0010, 2, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule